// File: doc/BRIEF.md
# Down-Counting Event Timer Bank

The block holds a row of identical event timers, one per processor, each of which counts down and raises a level-high interrupt when it expires. Software arms a timer by writing its control word. That word carries three things: an arm bit, a reload-mode bit and a 29-bit preset. The timer then counts once on every cycle in which the shared `tick` enable is high. That enable may be a microsecond strobe or may simply be held high so the timer counts at the oscillator rate.

A preset of N gives an expiry after N+1 ticks. In reload mode the timer loads the preset again and keeps running, so a preset of rate/HZ−1 yields HZ interrupts per second. In single-shot mode the expiry disarms the timer. The interrupt stays high until software writes a clear bit into the timer's status word.

Each timer has a control word and a status word. The bus address is a 32-bit word address. Timer k owns word 2k (control, byte offset 8k) and word 2k+1 (status, byte offset 8k+4). Reads return data in the same cycle. Each timer is built around a three-state machine:
- OFF: disarmed.
- ONCE: armed, single-shot.
- LOOP: armed, reloading.

Its transitions are:
- arm-once: OFF/ONCE/LOOP to ONCE, on a control write with bit 31 = 1 and bit 30 = 0.
- arm-loop: to LOOP, on a control write with bit 31 = 1 and bit 30 = 1.
- stop: ONCE/LOOP to OFF, on a control write with bit 31 = 0.
- fire-once: ONCE to OFF, on expiry.
- fire-loop: LOOP to LOOP, on expiry with reload.

Top module: `evt_timer_bank`

## Requirements
- R1: Control word layout: bit 31 = armed, bit 30 = reload mode, bits 28:0 = preset. Reading it back returns that layout, with bit 29 reading 0 and bit 31 showing whether the timer is currently armed.
- R2: After an arming write with preset N, the interrupt rises at the clock edge of the (N+1)-th tick. A preset of 0 fires on the first tick.
- R3: The count only moves in cycles where `tick` is 1. With `tick` low, the count is held.
- R4: In single-shot mode, expiry clears the armed bit, and later ticks raise no new interrupt.
- R5: In reload mode, expiry reloads the preset and the timer keeps counting, so the next interrupt comes N+1 ticks later.
- R6: A control write with bit 31 = 0 disarms the timer; no interrupt follows however many ticks arrive.
- R7: A status write with bit 30 = 1 drops the interrupt on the next edge. A status write with bit 30 = 0 leaves it unchanged.
- R8: The interrupt is a level that stays high across any number of cycles until it is cleared.
- R9: Timer k answers only at word addresses 2k and 2k+1 (byte offsets 8k and 8k+4). Accesses to one timer leave the other timers untouched.
- R10: An arming control write while the timer is running reloads the count from the new preset, and a tick in the same cycle is ignored.
- R11: The status word reads the current count in bits 28:0 and the pending flag in bit 30, with all other bits 0.
- R12: When a clear write and an expiry fall in the same cycle, the interrupt stays high.
- R13: The largest preset, 0x1FFFFFFF, is accepted and read back in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable shared by all timers |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (6) | Word address: 2k control, 2k+1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (0 when out of range) |
| irq | output | NUM_TMR (4) | Level-high interrupt per timer |

## Verification
Two events can land in the same cycle and must be ordered:
- A software clear write against a hardware expiry. The bench counts a reload timer down to zero, then presents the clear write together with the final tick. It judges the outcome by the interrupt still being high after that edge.
- An arming write against a tick. A restart issued mid-count must give a full N+1 ticks before expiry, never one fewer.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int WORD_W       = 32;
    localparam int CTL_ARM_BIT  = 31;
    localparam int CTL_LOOP_BIT = 30;
    localparam int STS_PEND_BIT = 30;
    localparam int PRESET_MAX_W = 29;

    typedef enum logic [1:0] {
        TS_OFF  = 2'd0,
        TS_ONCE = 2'd1,
        TS_LOOP = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/evt_tmr_decode.sv
module evt_tmr_decode #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 6
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_TMR-1:0] ctrl_we,
    output logic [NUM_TMR-1:0] stat_we
);
    localparam int SLOT_W = ADDR_W - 1;

    logic [SLOT_W-1:0] slot;
    logic              is_stat;

    assign slot    = bus_addr[ADDR_W-1:1];
    assign is_stat = bus_addr[0];

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_hit
        logic hit;
        assign hit        = bus_wr && (slot == SLOT_W'(k));
        assign ctrl_we[k] = hit && !is_stat;
        assign stat_we[k] = hit &&  is_stat;
    end

endmodule

// File: rtl/evt_tmr_core.sv
module evt_tmr_core
    import evt_tmr_pkg::*;
#(
    parameter int PRESET_W = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ctrl_we,
    input  logic                stat_we,
    input  logic                w_arm,
    input  logic                w_loop,
    input  logic                w_clr,
    input  logic [PRESET_W-1:0] w_preset,
    output logic [WORD_W-1:0]   ctrl_rd,
    output logic [WORD_W-1:0]   stat_rd,
    output logic                irq,
    output logic                run,
    output logic                looping,
    output logic                expire
);
    tmr_state_e          state_q, state_d;
    logic [PRESET_W-1:0] preset_q, cnt_q, cnt_d;
    logic                loop_q;
    logic                pend_q, pend_d;
    logic                at_zero;
    tmr_state_e          arm_target;

    assign at_zero    = (cnt_q == '0);
    assign run        = (state_q != TS_OFF);
    assign looping    = (state_q == TS_LOOP);
    assign expire     = run && tick && at_zero && !ctrl_we;
    assign arm_target = !w_arm ? TS_OFF : (w_loop ? TS_LOOP : TS_ONCE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_OFF: begin
                if (ctrl_we) state_d = arm_target;
            end
            TS_ONCE: begin
                if (ctrl_we)     state_d = arm_target;
                else if (expire) state_d = TS_OFF;
            end
            TS_LOOP: begin
                if (ctrl_we) state_d = arm_target;
            end
            default: state_d = TS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (ctrl_we && w_arm) begin
            cnt_d = w_preset;
        end else if (run && tick) begin
            if (!at_zero)              cnt_d = cnt_q - 1'b1;
            else if (state_q == TS_LOOP) cnt_d = preset_q;
        end
        if (expire)                  pend_d = 1'b1;
        else if (stat_we && w_clr)   pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            preset_q <= '0;
            loop_q   <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            if (ctrl_we) begin
                preset_q <= w_preset;
                loop_q   <= w_loop;
            end
        end
    end

    always_comb begin
        ctrl_rd                 = '0;
        ctrl_rd[PRESET_W-1:0]   = preset_q;
        ctrl_rd[CTL_LOOP_BIT]   = loop_q;
        ctrl_rd[CTL_ARM_BIT]    = run;
        stat_rd                 = '0;
        stat_rd[PRESET_W-1:0]   = cnt_q;
        stat_rd[STS_PEND_BIT]   = pend_q;
    end

    assign irq = pend_q;

endmodule

// File: rtl/evt_tmr_rdmux.sv
module evt_tmr_rdmux
    import evt_tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 6
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] ctrl_rd [NUM_TMR],
    input  logic [WORD_W-1:0] stat_rd [NUM_TMR],
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int SLOT_W = ADDR_W - 1;

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_TMR; k++) begin
            if (bus_addr[ADDR_W-1:1] == SLOT_W'(k))
                bus_rdata = bus_addr[0] ? stat_rd[k] : ctrl_rd[k];
        end
    end

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
    import evt_tmr_pkg::*;
#(
    parameter int NUM_TMR  = 4,
    parameter int ADDR_W   = 6,
    parameter int PRESET_W = PRESET_MAX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_TMR-1:0] irq
);
    logic [NUM_TMR-1:0] ctrl_we_v, stat_we_v;
    logic [NUM_TMR-1:0] run_v, loop_v, expire_v;
    logic [WORD_W-1:0]  ctrl_rd_a [NUM_TMR];
    logic [WORD_W-1:0]  stat_rd_a [NUM_TMR];

    evt_tmr_decode #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .ctrl_we  (ctrl_we_v),
        .stat_we  (stat_we_v)
    );

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        evt_tmr_core #(.PRESET_W(PRESET_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .ctrl_we  (ctrl_we_v[k]),
            .stat_we  (stat_we_v[k]),
            .w_arm    (bus_wdata[CTL_ARM_BIT]),
            .w_loop   (bus_wdata[CTL_LOOP_BIT]),
            .w_clr    (bus_wdata[STS_PEND_BIT]),
            .w_preset (bus_wdata[PRESET_W-1:0]),
            .ctrl_rd  (ctrl_rd_a[k]),
            .stat_rd  (stat_rd_a[k]),
            .irq      (irq[k]),
            .run      (run_v[k]),
            .looping  (loop_v[k]),
            .expire   (expire_v[k])
        );
    end

    evt_tmr_rdmux #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_rd (
        .bus_addr  (bus_addr),
        .ctrl_rd   (ctrl_rd_a),
        .stat_rd   (stat_rd_a),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/evt_timer_bank_chk.sv
module evt_timer_bank_chk #(
    parameter int NUM_TMR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        bus_wdata,
    input logic [NUM_TMR-1:0] ctrl_we_v,
    input logic [NUM_TMR-1:0] stat_we_v,
    input logic [NUM_TMR-1:0] run_v,
    input logic [NUM_TMR-1:0] loop_v,
    input logic [NUM_TMR-1:0] expire_v,
    input logic [NUM_TMR-1:0] irq
);
    logic clr_bit, arm_bit;
    assign clr_bit = bus_wdata[30];
    assign arm_bit = bus_wdata[31];

    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_we_v | stat_we_v));

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_chk
        a_r2_expiry_raises: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[k] |=> irq[k]);
        a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[k] && !(stat_we_v[k] && clr_bit)) |=> irq[k]);
        a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we_v[k] && clr_bit && !expire_v[k]) |=> !irq[k]);
        a_r12_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we_v[k] && clr_bit && expire_v[k]) |=> irq[k]);
        a_r4_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
            (expire_v[k] && !loop_v[k]) |=> !run_v[k]);
        a_r5_loop_rearms: assert property (@(posedge clk) disable iff (!rst_n)
            (expire_v[k] && loop_v[k]) |=> run_v[k]);
        a_r6_stop_write: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_we_v[k] && !arm_bit) |=> !run_v[k]);
    end

endmodule

bind evt_timer_bank evt_timer_bank_chk #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wdata (bus_wdata),
    .ctrl_we_v (ctrl_we_v),
    .stat_we_v (stat_we_v),
    .run_v     (run_v),
    .loop_v    (loop_v),
    .expire_v  (expire_v),
    .irq       (irq)
);

// File: tb/sim_evt_timer_bank.sv
`timescale 1ns/1ps
module sim_evt_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_timer_bank u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 reset irq", 32'(irq), 32'h0);
        rd(6'd0, d); chk("R1 reset ctrl", d, 32'h0);
        rd(6'd1, d); chk("R11 reset status", d, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        wr(6'd0, 32'h8000_0005);
        ticks(5);
        chk("R2 no irq after N ticks", 32'(irq[0]), 32'h0);
        rd(6'd1, d); chk("R11 count at zero", d, 32'h0);
        ticks(1);
        chk("R2 irq after N+1 ticks", 32'(irq[0]), 32'h1);
        rd(6'd0, d); chk("R4 armed bit cleared", d, 32'h0000_0005);
        ticks(10);
        chk("R8 irq holds", 32'(irq[0]), 32'h1);
        rd(6'd1, d); chk("R11 pending in status", d, 32'h4000_0000);
        wr(6'd1, 32'h0000_0000);
        chk("R7 clear bit 0 ignored", 32'(irq[0]), 32'h1);
        wr(6'd1, 32'h4000_0000);
        chk("R7 clear drops irq", 32'(irq[0]), 32'h0);
        ticks(10);
        chk("R4 no refire", 32'(irq[0]), 32'h0);
    endtask

    task automatic t_zero_preset;
        wr(6'd0, 32'h8000_0000);
        ticks(1);
        chk("R2 preset 0 one tick", 32'(irq[0]), 32'h1);
        wr(6'd1, 32'h4000_0000);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        wr(6'd2, 32'hC000_0003);
        ticks(4);
        chk("R9 timer1 fires", 32'(irq), 32'h2);
        wr(6'd3, 32'h4000_0000);
        ticks(3);
        chk("R5 not yet", 32'(irq[1]), 32'h0);
        ticks(1);
        chk("R5 refires", 32'(irq[1]), 32'h1);
        rd(6'd2, d); chk("R1 ctrl readback", d, 32'hC000_0003);
        wr(6'd3, 32'h4000_0000);
        ticks(3);
        // count is now 0: clear write and final tick share one edge
        tick = 1'b1;
        wr(6'd3, 32'h4000_0000);
        tick = 1'b0;
        chk("R12 expiry beats clear", 32'(irq[1]), 32'h1);
        rd(6'd3, d); chk("R5 reloaded count", d, 32'h4000_0003);
        wr(6'd3, 32'h4000_0000);
        wr(6'd2, 32'h0000_0000);
        ticks(20);
        chk("R6 stopped no irq", 32'(irq[1]), 32'h0);
        rd(6'd2, d); chk("R6 ctrl disarmed", d, 32'h0);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        wr(6'd4, 32'h8000_0006);
        ticks(4);
        rd(6'd5, d); chk("R11 mid count", d, 32'h0000_0002);
        tick = 1'b1;
        wr(6'd4, 32'h8000_0006);
        tick = 1'b0;
        rd(6'd5, d); chk("R10 reload ignores tick", d, 32'h0000_0006);
        ticks(6);
        chk("R10 no early fire", 32'(irq[2]), 32'h0);
        ticks(1);
        chk("R10 fires after full count", 32'(irq[2]), 32'h1);
        chk("R9 others quiet", 32'(irq), 32'h4);
        wr(6'd5, 32'h4000_0000);
    endtask

    task automatic t_gating;
        logic [31:0] d;
        wr(6'd6, 32'h8000_0009);
        idle(5);
        rd(6'd7, d); chk("R3 held without tick", d, 32'h0000_0009);
        ticks(2);
        rd(6'd7, d); chk("R3 counts with tick", d, 32'h0000_0007);
        wr(6'd6, 32'hFFFF_FFFF);
        rd(6'd6, d); chk("R13 max preset ctrl", d, 32'hDFFF_FFFF);
        rd(6'd7, d); chk("R13 max preset count", d, 32'h1FFF_FFFF);
        wr(6'd6, 32'h0);
        rd(6'd8, d); chk("R9 out of range reads 0", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_zero_preset();
        t_periodic();
        t_restart();
        t_gating();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule